// File: doc/BRIEF.md
# Dual-Space Word Memory Access Bridge

The bridge sits between a host that issues byte, halfword and word transfers and a target memory built from 16-bit words. The memory holds two separate spaces, program and data, chosen by one select line. The bridge takes each host request, works out the space and the word address from the flat host address, and issues the word accesses the transfer needs. When it is done, it returns one response carrying the read bytes or an error flag.

Host addresses are word addresses. An address from 0x200000 upwards lands in data space and is rebased to zero by subtracting 0x200000. The one exception is an address whose top byte is 0xFF: it keeps its full value so that registers mapped at the top of data space can still be reached. A 32-bit transfer becomes two back-to-back word accesses. A byte transfer carries one to four bytes, packed two to a word. If the byte count is odd, the last word is read first and written back with only its low byte replaced.

Top module: `mem_space_bridge`

## Requirements
- R1: A request whose host address is at least 0x200000 drives `mem_space_o`=1 (data) on all of its memory accesses. A lower address drives 0 (program).
- R2: For a data-space address whose bits [23:16] are not 0xFF, the memory word address is the host address minus 0x200000. For a data-space address with bits [23:16] equal to 0xFF, and for every program-space address, the word address is the host address unchanged.
- R3: Size code 2 (halfword) makes exactly one word access at the decoded address. A write stores `req_wdata_i[15:0]`. A read returns the word in `rsp_rdata_o[15:0]` with bits [31:16] zero.
- R4: Size code 4 (word) makes two accesses: first the decoded address with bits [15:0], then the decoded address plus one with bits [31:16]. A read returns {second word, first word}.
- R5: Size code 1 (byte) takes a byte count `req_bcnt_i` of 1 to 4, with byte i held in `req_wdata_i[8i+7:8i]`. Byte i maps to word address base + i/2, in the low half when i is even and the high half when i is odd. A write stores each complete byte pair in one word write, in ascending address order. A read issues ceil(count/2) word reads in ascending order and returns byte i in `rsp_rdata_o[8i+7:8i]`, with every byte at or above the count zero.
- R6: A byte write with an odd count ends with a read of word base + count/2, followed by a write to the same word. That write keeps the old bits [15:8] and puts the last host byte in bits [7:0].
- R7: A request with a size code other than 1, 2 or 4, or a byte request with a count of 0 or above 4, makes no memory access. It is answered with `rsp_err_o`=1 and `rsp_rdata_o`=0. A legal request is answered with `rsp_err_o`=0, and a legal write returns `rsp_rdata_o`=0.
- R8: `req_ready_o` is high only when no request is in progress. After a request is accepted, it stays low until the response handshake, so every memory access of a request, including the final write of a read-modify-write, finishes before the next request is taken.
- R9: While `mem_valid_o` is high and `mem_ready_i` is low, the memory request holds its address, space, direction and write data. While `rsp_valid_o` is high and `rsp_ready_i` is low, the response holds its data and error flag.
- R10: During reset, `req_ready_o`=1, `mem_valid_o`=0 and `rsp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Bridge is idle and accepts a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 3 | Transfer size code: 1 byte, 2 halfword, 4 word |
| req_bcnt_i | input | 3 | Byte count for size code 1 |
| req_addr_i | input | 24 | Flat host word address |
| req_wdata_i | input | 32 | Write data, byte i in bits [8i+7:8i] |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Host takes the response |
| rsp_err_o | output | 1 | Request was not legal |
| rsp_rdata_o | output | 32 | Read data |
| mem_valid_o | output | 1 | Memory access valid |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| mem_write_o | output | 1 | 1 = write, 0 = read |
| mem_space_o | output | 1 | 1 = data space, 0 = program space |
| mem_addr_o | output | 24 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with the read handshake |

## Verification
A wrong beat counter or a wrong next-state choice shows up at the memory port right away. The very next handshake carries an address, a direction or a space bit that the expected-access queue does not hold, or an access arrives after the response or is missing when the response arrives. Wrong capture of read data, wrong byte masking or a bad merge value shows up in the response data of that same request, or in the next read of the word that was damaged. A stuck-busy state shows up as a response that never arrives, or as `req_ready_o` rising in the middle of a request.

// File: rtl/mem_space_bridge_pkg.sv
package mem_space_bridge_pkg;
  localparam int WORD_W     = 16;
  localparam int HOST_W     = 32;
  localparam int HOST_BYTES = HOST_W / 8;
  localparam int BEAT_W     = 2;
  localparam int SIZE_W     = 3;
  localparam int CNT_W      = 3;

  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'd2;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_RESP
  } state_e;
endpackage

// File: rtl/mem_space_bridge_addr_map.sv
module mem_space_bridge_addr_map #(
  parameter int                ADDR_W    = 24,
  parameter int                TAG_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h200000,
  parameter logic [TAG_W-1:0]  PASS_TAG  = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              space_o,
  output logic [ADDR_W-1:0] waddr_o
);
  logic pass;

  assign space_o = (addr_i >= DATA_BASE);
  assign pass    = (addr_i[ADDR_W-1 -: TAG_W] == PASS_TAG);
  assign waddr_o = (space_o && !pass) ? (addr_i - DATA_BASE) : addr_i;
endmodule

// File: rtl/mem_space_bridge_plan.sv
module mem_space_bridge_plan
  import mem_space_bridge_pkg::*;
(
  input  logic [SIZE_W-1:0] size_i,
  input  logic [CNT_W-1:0]  bcnt_i,
  input  logic              write_i,
  output logic              legal_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic              rmw_o,
  output logic              is_byte_o
);
  logic [CNT_W:0] round_up;

  assign round_up = {1'b0, bcnt_i} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    legal_o   = 1'b0;
    beats_o   = '0;
    rmw_o     = 1'b0;
    is_byte_o = 1'b0;
    case (size_i)
      SZ_HALF: begin
        legal_o = 1'b1;
        beats_o = 2'd1;
      end
      SZ_WORD: begin
        legal_o = 1'b1;
        beats_o = 2'd2;
      end
      SZ_BYTE: begin
        is_byte_o = 1'b1;
        legal_o   = (bcnt_i != '0) && (bcnt_i <= CNT_W'(HOST_BYTES));
        // writes issue only whole pairs; the odd byte goes through rmw
        beats_o   = write_i ? bcnt_i[2:1] : round_up[2:1];
        rmw_o     = write_i & bcnt_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_space_bridge_lanes.sv
module mem_space_bridge_lanes
  import mem_space_bridge_pkg::*;
(
  input  logic [HOST_W-1:0] wdata_i,
  input  logic              beat_i,
  input  logic [CNT_W-1:0]  bcnt_i,
  input  logic [7:0]        old_hi_i,
  input  logic              byte_mode_i,
  output logic [WORD_W-1:0] beat_word_o,
  output logic [WORD_W-1:0] merge_word_o,
  output logic [HOST_W-1:0] keep_mask_o
);
  logic [7:0] bytes [HOST_BYTES];
  logic [1:0] last_idx;
  logic [CNT_W-1:0] last_cnt;

  for (genvar g = 0; g < HOST_BYTES; g++) begin : g_lane
    assign bytes[g] = wdata_i[8*g +: 8];
    assign keep_mask_o[8*g +: 8] =
      (!byte_mode_i || (bcnt_i > CNT_W'(g))) ? 8'hFF : 8'h00;
  end

  assign last_cnt     = bcnt_i - {{(CNT_W-1){1'b0}}, 1'b1};
  assign last_idx     = last_cnt[1:0];
  assign beat_word_o  = beat_i ? wdata_i[HOST_W-1:WORD_W] : wdata_i[WORD_W-1:0];
  assign merge_word_o = {old_hi_i, bytes[last_idx]};
endmodule

// File: rtl/mem_space_bridge_seq.sv
module mem_space_bridge_seq
  import mem_space_bridge_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [CNT_W-1:0]  req_bcnt_i,
  input  logic [HOST_W-1:0] req_wdata_i,
  input  logic              dec_space_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic              plan_legal_i,
  input  logic [BEAT_W-1:0] plan_beats_i,
  input  logic              plan_rmw_i,
  input  logic              plan_byte_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_err_o,
  output logic [HOST_W-1:0] rsp_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic              mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  state_e            state_q;
  logic              write_q, byte_q, rmw_q, err_q, space_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [BEAT_W-1:0] beats_q, beat_q, last_beat;
  logic [ADDR_W-1:0] base_q;
  logic [HOST_W-1:0] wdata_q, rdata_q;
  logic [7:0]        old_hi_q;
  logic [WORD_W-1:0] beat_word, merge_word;
  logic [HOST_W-1:0] keep_mask;

  mem_space_bridge_lanes u_lanes (
    .wdata_i     (wdata_q),
    .beat_i      (beat_q[0]),
    .bcnt_i      (bcnt_q),
    .old_hi_i    (old_hi_q),
    .byte_mode_i (byte_q),
    .beat_word_o (beat_word),
    .merge_word_o(merge_word),
    .keep_mask_o (keep_mask)
  );

  assign last_beat = beats_q - {{(BEAT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      write_q  <= 1'b0;
      byte_q   <= 1'b0;
      rmw_q    <= 1'b0;
      err_q    <= 1'b0;
      space_q  <= 1'b0;
      bcnt_q   <= '0;
      beats_q  <= '0;
      beat_q   <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      old_hi_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            write_q <= req_write_i;
            byte_q  <= plan_byte_i;
            rmw_q   <= plan_rmw_i;
            err_q   <= !plan_legal_i;
            space_q <= dec_space_i;
            bcnt_q  <= req_bcnt_i;
            beats_q <= plan_beats_i;
            beat_q  <= '0;
            base_q  <= dec_addr_i;
            wdata_q <= req_wdata_i;
            rdata_q <= '0;
            if (!plan_legal_i)              state_q <= ST_RESP;
            else if (plan_beats_i == '0)    state_q <= ST_RMW_RD;
            else                            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (mem_ready_i) begin
            if (!write_q) begin
              if (beat_q[0]) rdata_q[HOST_W-1:WORD_W] <= mem_rdata_i;
              else           rdata_q[WORD_W-1:0]      <= mem_rdata_i;
            end
            if (beat_q == last_beat) state_q <= rmw_q ? ST_RMW_RD : ST_RESP;
            else                     beat_q  <= beat_q + {{(BEAT_W-1){1'b0}}, 1'b1};
          end
        end
        ST_RMW_RD: begin
          if (mem_ready_i) begin
            old_hi_q <= mem_rdata_i[WORD_W-1:8];
            state_q  <= ST_RMW_WR;
          end
        end
        ST_RMW_WR: begin
          if (mem_ready_i) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q & keep_mask;
  assign mem_space_o = space_q;

  always_comb begin
    mem_valid_o = 1'b0;
    mem_write_o = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    case (state_q)
      ST_ACCESS: begin
        mem_valid_o = 1'b1;
        mem_write_o = write_q;
        mem_addr_o  = base_q + {{(ADDR_W-BEAT_W){1'b0}}, beat_q};
        mem_wdata_o = beat_word;
      end
      ST_RMW_RD: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = base_q + {{(ADDR_W-BEAT_W){1'b0}}, beats_q};
      end
      ST_RMW_WR: begin
        mem_valid_o = 1'b1;
        mem_write_o = 1'b1;
        mem_addr_o  = base_q + {{(ADDR_W-BEAT_W){1'b0}}, beats_q};
        mem_wdata_o = merge_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_space_bridge.sv
module mem_space_bridge
  import mem_space_bridge_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                TAG_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h200000,
  parameter logic [TAG_W-1:0]  PASS_TAG  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [CNT_W-1:0]  req_bcnt_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [HOST_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_err_o,
  output logic [HOST_W-1:0] rsp_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic              mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic              dec_space;
  logic [ADDR_W-1:0] dec_addr;
  logic              plan_legal, plan_rmw, plan_byte;
  logic [BEAT_W-1:0] plan_beats;

  mem_space_bridge_addr_map #(
    .ADDR_W   (ADDR_W),
    .TAG_W    (TAG_W),
    .DATA_BASE(DATA_BASE),
    .PASS_TAG (PASS_TAG)
  ) u_map (
    .addr_i (req_addr_i),
    .space_o(dec_space),
    .waddr_o(dec_addr)
  );

  mem_space_bridge_plan u_plan (
    .size_i   (req_size_i),
    .bcnt_i   (req_bcnt_i),
    .write_i  (req_write_i),
    .legal_o  (plan_legal),
    .beats_o  (plan_beats),
    .rmw_o    (plan_rmw),
    .is_byte_o(plan_byte)
  );

  mem_space_bridge_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_bcnt_i  (req_bcnt_i),
    .req_wdata_i (req_wdata_i),
    .dec_space_i (dec_space),
    .dec_addr_i  (dec_addr),
    .plan_legal_i(plan_legal),
    .plan_beats_i(plan_beats),
    .plan_rmw_i  (plan_rmw),
    .plan_byte_i (plan_byte),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_write_o (mem_write_o),
    .mem_space_o (mem_space_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: rtl/mem_space_bridge_chk.sv
module mem_space_bridge_chk
  import mem_space_bridge_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h200000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [SIZE_W-1:0] req_size_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic              rsp_err_o,
  input logic [HOST_W-1:0] rsp_rdata_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_write_o,
  input logic              mem_space_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o
);
  logic exp_space_q;
  logic bad_size;

  assign bad_size = (req_size_i != SZ_BYTE) && (req_size_i != SZ_HALF) &&
                    (req_size_i != SZ_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         exp_space_q <= 1'b0;
    else if (req_valid_i && req_ready_o) exp_space_q <= (req_addr_i >= DATA_BASE);
  end

  assert_reset_idle_R10: assert property (@(posedge clk_i)
    !rst_ni |-> req_ready_o && !mem_valid_o && !rsp_valid_o);

  assert_space_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_space_o == exp_space_q);

  assert_bad_size_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && bad_size |=> rsp_valid_o && rsp_err_o && !mem_valid_o);

  assert_err_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);

  assert_busy_no_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !rsp_valid_o);

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_write_o) && $stable(mem_space_o) && $stable(mem_wdata_o));

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) &&
      $stable(rsp_err_o));
endmodule

bind mem_space_bridge mem_space_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_BASE(DATA_BASE)
) chk_i (.*);

// File: tb/mem_space_bridge_tb_top.sv
module mem_space_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [2:0]  req_size_i = '0;
  logic [2:0]  req_bcnt_i = '0;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_write_o;
  logic        mem_space_o;
  logic [23:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R10";

  typedef struct packed {
    logic        w;
    logic        sp;
    logic [23:0] a;
    logic [15:0] d;
  } acc_t;

  acc_t exp_q[$];
  logic [15:0] pmem [int];
  logic [15:0] dmem [int];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_space_bridge dut_i (.*);

  function automatic logic [15:0] dflt(logic sp, logic [23:0] a);
    return a[15:0] ^ (sp ? 16'h5A5A : 16'hC3C3);
  endfunction

  function logic [15:0] mread(logic sp, logic [23:0] a);
    if (sp) return dmem.exists(int'(a)) ? dmem[int'(a)] : dflt(sp, a);
    return pmem.exists(int'(a)) ? pmem[int'(a)] : dflt(sp, a);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder and access monitor
  initial begin
    logic [7:0] pat;
    acc_t e;
    pat = 8'b1101_0110;
    forever begin
      @(negedge clk_i);
      pat = {pat[6:0], pat[7]};
      mem_ready_i = pat[0];
      if (mem_valid_o && mem_ready_i) begin
        mem_rdata_i = mread(mem_space_o, mem_addr_o);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected access actual=%b/%b/%h/%h expected=none",
                   cur_tag, mem_write_o, mem_space_o, mem_addr_o, mem_wdata_o);
        end else begin
          e = exp_q.pop_front();
          if (mem_write_o !== e.w || mem_space_o !== e.sp || mem_addr_o !== e.a ||
              (e.w && mem_wdata_o !== e.d)) begin
            errors++;
            $display("FAIL %s access actual=%b/%b/%h/%h expected=%b/%b/%h/%h", cur_tag,
                     mem_write_o, mem_space_o, mem_addr_o, mem_wdata_o, e.w, e.sp, e.a, e.d);
          end
        end
        if (mem_write_o) begin
          if (mem_space_o) dmem[int'(mem_addr_o)] = mem_wdata_o;
          else             pmem[int'(mem_addr_o)] = mem_wdata_o;
        end
      end
    end
  end

  task automatic run_req(string tag, logic w, logic [2:0] sz, logic [2:0] bc,
                         logic [23:0] ad, logic [31:0] wd, int hold);
    logic        sp, ee;
    logic [23:0] a;
    logic [31:0] er, held_d;
    logic [15:0] old, wv;
    logic        held_e;
    cur_tag = tag;
    sp = (ad >= 24'h200000);
    a  = (sp && ad[23:16] != 8'hFF) ? ad - 24'h200000 : ad;
    er = '0;
    ee = 1'b0;
    if (sz == 3'd2) begin
      exp_q.push_back({w, sp, a, w ? wd[15:0] : 16'h0});
      if (!w) er = {16'h0, mread(sp, a)};
    end else if (sz == 3'd4) begin
      exp_q.push_back({w, sp, a, w ? wd[15:0] : 16'h0});
      exp_q.push_back({w, sp, a + 24'd1, w ? wd[31:16] : 16'h0});
      if (!w) er = {mread(sp, a + 24'd1), mread(sp, a)};
    end else if (sz == 3'd1 && bc >= 3'd1 && bc <= 3'd4) begin
      if (!w) begin
        for (int k = 0; k < (int'(bc) + 1) / 2; k++)
          exp_q.push_back({1'b0, sp, a + 24'(k), 16'h0});
        for (int i = 0; i < int'(bc); i++) begin
          wv = mread(sp, a + 24'(i / 2));
          er[8*i +: 8] = (i % 2) ? wv[15:8] : wv[7:0];
        end
      end else begin
        for (int k = 0; k < int'(bc) / 2; k++)
          exp_q.push_back({1'b1, sp, a + 24'(k), wd[16*k +: 16]});
        if (bc[0]) begin
          old = mread(sp, a + 24'(bc / 2));
          exp_q.push_back({1'b0, sp, a + 24'(bc / 2), 16'h0});
          exp_q.push_back({1'b1, sp, a + 24'(bc / 2), {old[15:8], wd[8*(bc-1) +: 8]}});
        end
      end
    end else begin
      ee = 1'b1;
    end

    @(negedge clk_i);
    req_write_i = w;
    req_size_i  = sz;
    req_bcnt_i  = bc;
    req_addr_i  = ad;
    req_wdata_i = wd;
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) begin
      if (req_ready_o) begin
        errors++;
        $display("FAIL R8 %s ready while busy actual=1 expected=0", tag);
      end
      @(negedge clk_i);
    end
    if (hold > 0) begin
      held_d = rsp_rdata_o;
      held_e = rsp_err_o;
      repeat (hold) @(negedge clk_i);
      chk("R9", "rsp still valid", {31'h0, rsp_valid_o}, 32'h1);
      chk("R9", "rsp data held", rsp_rdata_o, held_d);
      chk("R9", "rsp err held", {31'h0, rsp_err_o}, {31'h0, held_e});
    end
    chk(tag, "rsp err", {31'h0, rsp_err_o}, {31'h0, ee});
    chk(tag, "rsp data", rsp_rdata_o, er);
    chk("R8", "all accesses done before response", exp_q.size(), 0);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10", "req_ready in reset", {31'h0, req_ready_o}, 32'h1);
    chk("R10", "mem_valid in reset", {31'h0, mem_valid_o}, 32'h0);
    chk("R10", "rsp_valid in reset", {31'h0, rsp_valid_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 R3: program halfword
    run_req("R3", 1'b1, 3'd2, 3'd0, 24'h000100, 32'h0000BEEF, 0);
    run_req("R3", 1'b0, 3'd2, 3'd0, 24'h000100, 32'h0, 0);
    run_req("R1", 1'b0, 3'd2, 3'd0, 24'h1FFFFF, 32'h0, 0);
    // R2: data space rebasing and top window pass-through
    run_req("R2", 1'b1, 3'd2, 3'd0, 24'h200010, 32'h00001234, 0);
    run_req("R2", 1'b1, 3'd2, 3'd0, 24'h000010, 32'h00009999, 0);
    run_req("R2", 1'b0, 3'd2, 3'd0, 24'h200010, 32'h0, 2);
    run_req("R1", 1'b0, 3'd2, 3'd0, 24'h200000, 32'h0, 0);
    run_req("R2", 1'b1, 3'd2, 3'd0, 24'hFF0004, 32'h0000CAFE, 0);
    run_req("R2", 1'b0, 3'd2, 3'd0, 24'hFF0004, 32'h0, 0);
    run_req("R2", 1'b0, 3'd2, 3'd0, 24'hFEFFFF, 32'h0, 0);
    // R4: 32-bit split
    run_req("R4", 1'b1, 3'd4, 3'd0, 24'h000200, 32'h12345678, 0);
    run_req("R4", 1'b0, 3'd4, 3'd0, 24'h000200, 32'h0, 3);
    run_req("R4", 1'b0, 3'd4, 3'd0, 24'h200100, 32'h0, 0);
    run_req("R4", 1'b0, 3'd4, 3'd0, 24'h1FFFFF, 32'h0, 0);
    // R5: byte packing
    run_req("R5", 1'b1, 3'd1, 3'd4, 24'h000300, 32'hA1B2C3D4, 0);
    run_req("R5", 1'b0, 3'd1, 3'd4, 24'h000300, 32'h0, 0);
    run_req("R5", 1'b0, 3'd1, 3'd2, 24'h000301, 32'h0, 0);
    run_req("R5", 1'b0, 3'd1, 3'd3, 24'h000300, 32'h0, 1);
    run_req("R5", 1'b0, 3'd1, 3'd1, 24'h000301, 32'h0, 0);
    run_req("R5", 1'b1, 3'd1, 3'd2, 24'h200040, 32'hFFFF5566, 0);
    run_req("R5", 1'b0, 3'd1, 3'd2, 24'h200040, 32'h0, 0);
    // R6: odd byte counts use read-modify-write
    run_req("R6", 1'b1, 3'd1, 3'd3, 24'h000300, 32'h77EEDDCC, 0);
    run_req("R6", 1'b0, 3'd1, 3'd4, 24'h000300, 32'h0, 0);
    run_req("R6", 1'b1, 3'd1, 3'd1, 24'h200050, 32'hFFFFFF3C, 0);
    run_req("R6", 1'b0, 3'd2, 3'd0, 24'h200050, 32'h0, 0);
    run_req("R6", 1'b1, 3'd1, 3'd1, 24'h000400, 32'h00000011, 0);
    run_req("R6", 1'b0, 3'd2, 3'd0, 24'h000400, 32'h0, 0);
    // R7: illegal requests
    run_req("R7", 1'b1, 3'd0, 3'd2, 24'h000500, 32'h11112222, 0);
    run_req("R7", 1'b0, 3'd3, 3'd2, 24'h000500, 32'h0, 2);
    run_req("R7", 1'b1, 3'd7, 3'd1, 24'h200500, 32'h11112222, 0);
    run_req("R7", 1'b1, 3'd1, 3'd0, 24'h000500, 32'h11112222, 0);
    run_req("R7", 1'b0, 3'd1, 3'd5, 24'h000500, 32'h0, 0);
    run_req("R7", 1'b0, 3'd2, 3'd0, 24'h000500, 32'h0, 0);

    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule